// File: doc/BRIEF.md
# Asynchronous Memory Read Controller with Wait-Pin Handling

This block runs read cycles against an external asynchronous memory: single-word reads and page-mode reads of up to four words. A host hands it an address through a simple request port. The block then drives the chip-select, address-valid and output-enable strobes. Each strobe has its own assert and deassert time, and all of them are measured on a timing counter that counts interface ticks from the moment the request is accepted. The interface tick is the functional clock divided by a setting of one to four.

The memory can stretch an access by pulling an active-low WAIT line. The line passes through a fixed two-stage synchronizer and is looked at only once the timing counter reaches the access point of the current word. While WAIT is seen active, the timing counter is frozen, so every strobe holds its level and the cycle end moves out. When WAIT is released, an optional delay of zero to three ticks runs before the word is captured and the counter moves again. In page mode the next word's access point then follows a programmed step later. If WAIT stays active for too long, the access is abandoned and the host receives an error response.

Top module: `amrd_wait_ctrl`

## Requirements
- R1: While reset is held, and on the first clock after it, req_ready is 1, rsp_valid and rsp_err are 0, and mem_cs_n, mem_adv_n and mem_oe_n are all 1.
- R2: The timing count is 0 at acceptance and rises by one per tick. Each strobe (chip-select, address-valid, output-enable) is driven low exactly while its on time is at or below the count and the count is below its off time.
- R3: Ticks come every cfg_div+1 clocks (cfg_div from 0 to 3). The first tick falls cfg_div+1 clocks after the accepting clock edge.
- R4: With WAIT inactive, a word is captured on the tick at which the count equals its access point. The access point of the first word is cfg_access. rsp_valid is high for one clock after that edge, with rsp_data equal to mem_data_in as sampled at that edge.
- R5: A read returns cfg_words+1 words. For word j, mem_addr is the request address plus j, and each word's access point lies cfg_page_step ticks after the previous word's.
- R6: mem_wait_n is active low and reaches the control logic through exactly two clock stages. A WAIT pulse that is no longer seen by the access point has no effect.
- R7: While WAIT is seen at or after an access point, the count and all strobes are frozen. The remaining cycle is shifted by the number of ticks spent frozen.
- R8: After WAIT is seen released on a tick, the capture and the restart of the counter take place cfg_wait_dly ticks later (0 to 3).
- R9: If WAIT is still seen active on the cfg_timeout+1-th tick after the freeze begins, the access ends. rsp_valid and rsp_err are then both high for one clock, and req_ready returns right after.
- R10: req_ready is 1 only when no access is in progress, and all strobes are high whenever it is. After a read, it returns cfg_cycle ticks after acceptance plus any frozen and delay ticks.
- R11: Every read without an error produces exactly one rsp_valid pulse per word, and rsp_err stays 0 on all of them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Functional clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_div | input | 2 | Interface tick divider minus one |
| cfg_cs_on | input | TW | Chip-select assert count |
| cfg_cs_off | input | TW | Chip-select deassert count |
| cfg_adv_on | input | TW | Address-valid assert count |
| cfg_adv_off | input | TW | Address-valid deassert count |
| cfg_oe_on | input | TW | Output-enable assert count |
| cfg_oe_off | input | TW | Output-enable deassert count |
| cfg_access | input | TW | Access point of the first word |
| cfg_page_step | input | TW | Ticks between page words |
| cfg_cycle | input | TW | Cycle length in ticks |
| cfg_words | input | 2 | Words per read minus one |
| cfg_wait_dly | input | 2 | Extra ticks from WAIT release to capture |
| cfg_timeout | input | TOW | Frozen ticks tolerated before abort |
| req_valid | input | 1 | Read request |
| req_addr | input | AW | Word address of the read |
| req_ready | output | 1 | Controller idle, request accepted |
| rsp_valid | output | 1 | One-clock response pulse |
| rsp_data | output | DW | Captured word |
| rsp_err | output | 1 | Response is a timeout abort |
| mem_addr | output | AW | Memory address |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_adv_n | output | 1 | Address valid, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_data_in | input | DW | Memory read data |
| mem_wait_n | input | 1 | Memory wait, active low |

## Verification
The embedded properties take three things for granted. First, the configuration stays put while an access is running. Second, every on and off time, every access point and the cycle length fit the timing counter, with the cycle ending at least two ticks after the last access point. Third, the page step is at least one. The stimulus sets the timing fields once before any request and changes only the divider, the page length, the delay and the timeout between accesses, after req_ready has returned. WAIT is held low only over a window counted from the accepting edge and is raised again before the next request, so no property sees a WAIT level left over from an earlier access.

// File: rtl/amrd_pkg.sv
// Shared types for the asynchronous memory read controller.
// Assumes nothing beyond the IEEE 1800-2017 language.
package amrd_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,   // waiting for a request
        ST_RUN,    // counting toward the next access point
        ST_HOLD,   // counter frozen by WAIT
        ST_DLY,    // extra delay after WAIT release
        ST_TAIL    // remaining cycle after the last word
    } amrd_state_e;

    localparam int NUM_STB = 3;   // chip-select, address-valid, output-enable
    localparam int STB_CS  = 0;
    localparam int STB_ADV = 1;
    localparam int STB_OE  = 2;

endpackage

// File: rtl/amrd_tick_gen.sv
// Divides the functional clock into interface ticks.
// Emits one tick every cfg_div+1 clocks. clr holds the phase at zero,
// so that the first tick after clr drops lands cfg_div+1 clocks later.
// Assumes cfg_div is stable while clr is low.
module amrd_tick_gen #(
    parameter int DIV_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic [DIV_W-1:0] cfg_div,
    output logic             tick
);
    logic [DIV_W-1:0] phase;

    assign tick = (phase == cfg_div);

    // phase counter, restarted on clr or after each tick
    always_ff @(posedge clk) begin
        if (!rst_n)            phase <= '0;
        else if (clr || tick)  phase <= '0;
        else                   phase <= phase + 1'b1;
    end

    // R3
    tick_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !clr && cfg_div != '0) |=> (!tick || cfg_div == '0));

endmodule

// File: rtl/amrd_wait_sync.sv
// Brings the asynchronous active-low WAIT pin into the clock domain
// through a fixed pipeline of STAGES flops. Output is active high.
// Assumes the pin is glitch-free relative to the flop settling time.
module amrd_wait_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic wait_n,
    output logic wait_act
);
    logic [STAGES-1:0] pipe;

    // shift the pin through the pipeline, reset to inactive
    always_ff @(posedge clk) begin
        if (!rst_n) pipe <= '1;
        else        pipe <= {pipe[STAGES-2:0], wait_n};
    end

    assign wait_act = !pipe[STAGES-1];

    generate
        if (STAGES == 2) begin : g_chk2
            logic [1:0] warm;
            // count two clocks out of reset before comparing history
            always_ff @(posedge clk) begin
                if (!rst_n)            warm <= '0;
                else if (warm != 2'd2) warm <= warm + 1'b1;
            end
            // R6
            wait_pipe_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (warm == 2'd2) |-> (wait_act == !$past(wait_n, 2)));
        end
    endgenerate

endmodule

// File: rtl/amrd_strobe_win.sv
// Decodes one active-low strobe from the timing count.
// The strobe is low while active and t_on <= count < t_off.
// Purely combinational; assumes t_on and t_off fit the count width.
module amrd_strobe_win #(
    parameter int TW = 6
) (
    input  logic          active,
    input  logic [TW-1:0] tcnt,
    input  logic [TW-1:0] t_on,
    input  logic [TW-1:0] t_off,
    output logic          strobe_n
);
    // window compare
    always_comb begin
        strobe_n = !(active && (tcnt >= t_on) && (tcnt < t_off));
    end

endmodule

// File: rtl/amrd_wait_ctrl.sv
// Asynchronous single and page read controller with WAIT handling.
// Accepts a request while idle and runs a timing counter in interface
// ticks. The counter freezes while WAIT is seen at an access point,
// captures each word (after an optional delay once WAIT is released)
// and aborts with an error after a timeout.
// Assumes configuration is stable during an access, cfg_page_step >= 1,
// and cfg_cycle at least two ticks past the last access point.
module amrd_wait_ctrl
    import amrd_pkg::*;
#(
    parameter int AW    = 10,
    parameter int DW    = 16,
    parameter int TW    = 6,
    parameter int TOW   = 8,
    parameter int DIV_W = 2,
    parameter int PW    = 2,
    parameter int DLY_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] cfg_div,
    input  logic [TW-1:0]    cfg_cs_on,
    input  logic [TW-1:0]    cfg_cs_off,
    input  logic [TW-1:0]    cfg_adv_on,
    input  logic [TW-1:0]    cfg_adv_off,
    input  logic [TW-1:0]    cfg_oe_on,
    input  logic [TW-1:0]    cfg_oe_off,
    input  logic [TW-1:0]    cfg_access,
    input  logic [TW-1:0]    cfg_page_step,
    input  logic [TW-1:0]    cfg_cycle,
    input  logic [PW-1:0]    cfg_words,
    input  logic [DLY_W-1:0] cfg_wait_dly,
    input  logic [TOW-1:0]   cfg_timeout,
    input  logic             req_valid,
    input  logic [AW-1:0]    req_addr,
    output logic             req_ready,
    output logic             rsp_valid,
    output logic [DW-1:0]    rsp_data,
    output logic             rsp_err,
    output logic [AW-1:0]    mem_addr,
    output logic             mem_cs_n,
    output logic             mem_adv_n,
    output logic             mem_oe_n,
    input  logic [DW-1:0]    mem_data_in,
    input  logic             mem_wait_n
);
    amrd_state_e      state;
    logic [TW-1:0]    tcnt;
    logic [TW-1:0]    acc_pt;
    logic [PW-1:0]    word;
    logic [AW-1:0]    base;
    logic [DLY_W-1:0] dly_cnt;
    logic [TOW-1:0]   to_cnt;
    logic             tick;
    logic             wait_act;
    logic             cap_now;
    logic             last_word;
    logic             cyc_done;
    logic             busy;

    logic [NUM_STB-1:0][TW-1:0] on_t;
    logic [NUM_STB-1:0][TW-1:0] off_t;
    logic [NUM_STB-1:0]         stb_n;

    assign busy      = (state != ST_IDLE);
    assign req_ready = !busy;
    assign last_word = (word == cfg_words);
    assign cyc_done  = ({1'b0, tcnt} + 1'b1) >= {1'b0, cfg_cycle};
    assign mem_addr  = base + AW'(word);

    amrd_tick_gen #(.DIV_W(DIV_W)) u_tick (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (!busy),
        .cfg_div (cfg_div),
        .tick    (tick)
    );

    amrd_wait_sync #(.STAGES(2)) u_wsync (
        .clk      (clk),
        .rst_n    (rst_n),
        .wait_n   (mem_wait_n),
        .wait_act (wait_act)
    );

    assign on_t[STB_CS]   = cfg_cs_on;
    assign off_t[STB_CS]  = cfg_cs_off;
    assign on_t[STB_ADV]  = cfg_adv_on;
    assign off_t[STB_ADV] = cfg_adv_off;
    assign on_t[STB_OE]   = cfg_oe_on;
    assign off_t[STB_OE]  = cfg_oe_off;

    generate
        for (genvar g = 0; g < NUM_STB; g++) begin : g_stb
            amrd_strobe_win #(.TW(TW)) u_win (
                .active   (busy),
                .tcnt     (tcnt),
                .t_on     (on_t[g]),
                .t_off    (off_t[g]),
                .strobe_n (stb_n[g])
            );
        end
    endgenerate

    assign mem_cs_n  = stb_n[STB_CS];
    assign mem_adv_n = stb_n[STB_ADV];
    assign mem_oe_n  = stb_n[STB_OE];

    // decide whether the data bus is captured on this tick
    always_comb begin
        cap_now = 1'b0;
        if (tick) begin
            case (state)
                ST_RUN:  cap_now = (tcnt == acc_pt) && !wait_act;
                ST_HOLD: cap_now = !wait_act && (cfg_wait_dly == '0);
                ST_DLY:  cap_now = (dly_cnt == cfg_wait_dly);
                default: cap_now = 1'b0;
            endcase
        end
    end

    // access sequencer: counters, state and response register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            tcnt      <= '0;
            acc_pt    <= '0;
            word      <= '0;
            base      <= '0;
            dly_cnt   <= '0;
            to_cnt    <= '0;
            rsp_valid <= 1'b0;
            rsp_err   <= 1'b0;
            rsp_data  <= '0;
        end else begin
            rsp_valid <= 1'b0;
            rsp_err   <= 1'b0;
            if (cap_now) begin
                rsp_valid <= 1'b1;
                rsp_data  <= mem_data_in;
                tcnt      <= tcnt + 1'b1;
                if (last_word) begin
                    state <= ST_TAIL;
                end else begin
                    state  <= ST_RUN;
                    word   <= word + 1'b1;
                    acc_pt <= acc_pt + cfg_page_step;
                end
            end else if (tick || state == ST_IDLE) begin
                case (state)
                    ST_IDLE: begin
                        if (req_valid) begin
                            base   <= req_addr;
                            tcnt   <= '0;
                            acc_pt <= cfg_access;
                            word   <= '0;
                            state  <= ST_RUN;
                        end
                    end
                    ST_RUN: begin
                        if (tcnt == acc_pt) begin
                            state  <= ST_HOLD;
                            to_cnt <= '0;
                        end else begin
                            tcnt <= tcnt + 1'b1;
                        end
                    end
                    ST_HOLD: begin
                        if (!wait_act) begin
                            state   <= ST_DLY;
                            dly_cnt <= DLY_W'(1);
                        end else if (to_cnt == cfg_timeout) begin
                            state     <= ST_IDLE;
                            rsp_valid <= 1'b1;
                            rsp_err   <= 1'b1;
                        end else begin
                            to_cnt <= to_cnt + 1'b1;
                        end
                    end
                    ST_DLY:  dly_cnt <= dly_cnt + 1'b1;
                    ST_TAIL: begin
                        if (cyc_done) state <= ST_IDLE;
                        else          tcnt  <= tcnt + 1'b1;
                    end
                    default: state <= ST_IDLE;
                endcase
            end
        end
    end

    // R7
    hold_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HOLD && $past(state) == ST_HOLD) |-> (tcnt == $past(tcnt)));

    // R9
    err_from_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_err |-> (rsp_valid && $past(state) == ST_HOLD));

    // R10
    idle_strobes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (mem_cs_n && mem_adv_n && mem_oe_n));

    // R4
    rsp_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(tick));

endmodule

// File: tb/amrd_wait_ctrl_tb.sv
// Self-checking bench: a vector table walked by one loop, then directed
// tests for reset, timeout boundaries and reset during an access.
module amrd_wait_ctrl_tb_top;

    localparam int ACC  = 4;
    localparam int STEP = 2;
    localparam int CYC  = 12;
    localparam int CSON = 0,  CSOFF = 12;
    localparam int AVON = 0,  AVOFF = 2;
    localparam int OEON = 3,  OEOFF = 11;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  cfg_div = '0;
    logic [1:0]  cfg_words = '0;
    logic [1:0]  cfg_wait_dly = '0;
    logic [7:0]  cfg_timeout = 8'd20;
    logic        req_valid = 1'b0;
    logic [9:0]  req_addr = '0;
    logic        req_ready, rsp_valid, rsp_err;
    logic [15:0] rsp_data, mem_data_in;
    logic [9:0]  mem_addr;
    logic        mem_cs_n, mem_adv_n, mem_oe_n;
    logic        mem_wait_n = 1'b1;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    function automatic logic [15:0] mdl(input logic [9:0] a);
        return (16'(a) * 16'd37) ^ 16'hC35A;
    endfunction

    assign mem_data_in = mdl(mem_addr);

    amrd_wait_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_div(cfg_div),
        .cfg_cs_on(6'(CSON)), .cfg_cs_off(6'(CSOFF)),
        .cfg_adv_on(6'(AVON)), .cfg_adv_off(6'(AVOFF)),
        .cfg_oe_on(6'(OEON)), .cfg_oe_off(6'(OEOFF)),
        .cfg_access(6'(ACC)), .cfg_page_step(6'(STEP)), .cfg_cycle(6'(CYC)),
        .cfg_words(cfg_words), .cfg_wait_dly(cfg_wait_dly), .cfg_timeout(cfg_timeout),
        .req_valid(req_valid), .req_addr(req_addr), .req_ready(req_ready),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_err(rsp_err),
        .mem_addr(mem_addr), .mem_cs_n(mem_cs_n), .mem_adv_n(mem_adv_n),
        .mem_oe_n(mem_oe_n), .mem_data_in(mem_data_in), .mem_wait_n(mem_wait_n)
    );

    // div, words-1, delay, WAIT low through edge rel, first capture edge, ready edge
    typedef struct packed {
        logic [1:0] div;
        logic [1:0] wm1;
        logic [1:0] dly;
        logic [7:0] rel;
        logic [7:0] cap0;
        logic [7:0] rdy;
    } vec_t;

    localparam int NV = 11;
    localparam vec_t VECS [NV] = '{
        '{2'd0, 2'd0, 2'd0, 8'd0,  8'd5,  8'd12},
        '{2'd1, 2'd0, 2'd0, 8'd0,  8'd10, 8'd24},
        '{2'd3, 2'd1, 2'd0, 8'd0,  8'd20, 8'd48},
        '{2'd0, 2'd3, 2'd0, 8'd0,  8'd5,  8'd12},
        '{2'd0, 2'd0, 2'd0, 8'd10, 8'd13, 8'd20},
        '{2'd0, 2'd0, 2'd2, 8'd10, 8'd15, 8'd22},
        '{2'd0, 2'd0, 2'd3, 8'd10, 8'd16, 8'd23},
        '{2'd1, 2'd0, 2'd1, 8'd10, 8'd16, 8'd30},
        '{2'd0, 2'd0, 2'd0, 8'd2,  8'd5,  8'd12},
        '{2'd0, 2'd1, 2'd1, 8'd10, 8'd14, 8'd21},
        '{2'd0, 2'd0, 2'd0, 8'd3,  8'd6,  8'd13}
    };

    int          ev_n [8];
    logic [15:0] ev_d [8];
    logic        ev_e [8];
    int          ev_cnt;
    int          rdy_n;
    logic        s_cs [256];
    logic        s_av [256];
    logic        s_oe [256];

    task automatic chk(input bit ok, input string req, input int got, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s got=%0d exp=%0d", req, got, exp);
        end
    endtask

    // run one read, record responses, ready edge and strobes per clock
    task automatic do_access(input logic [1:0] div, input logic [1:0] wm1,
                             input logic [1:0] dly, input int rel,
                             input logic [9:0] base);
        cfg_div = div; cfg_words = wm1; cfg_wait_dly = dly;
        ev_cnt = 0; rdy_n = -1;
        @(negedge clk);
        req_addr = base; req_valid = 1'b1; mem_wait_n = 1'b1;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        mem_wait_n = (1 <= rel) ? 1'b0 : 1'b1;
        for (int n = 1; n < 256 && rdy_n < 0; n++) begin
            @(posedge clk);
            @(negedge clk);
            s_cs[n] = mem_cs_n; s_av[n] = mem_adv_n; s_oe[n] = mem_oe_n;
            if (rsp_valid) begin
                if (ev_cnt < 8) begin
                    ev_n[ev_cnt] = n; ev_d[ev_cnt] = rsp_data; ev_e[ev_cnt] = rsp_err;
                end
                ev_cnt++;
            end
            if (req_ready) rdy_n = n;
            mem_wait_n = (n + 1 <= rel) ? 1'b0 : 1'b1;
        end
        mem_wait_n = 1'b1;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog got=%0d exp=%0d", 0, 1);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1 state while reset is held
        chk(req_ready && !rsp_valid && !rsp_err && mem_cs_n && mem_adv_n && mem_oe_n,
            "R1 reset outputs", {req_ready, rsp_valid, rsp_err, mem_cs_n, mem_adv_n, mem_oe_n}, 6'b100111);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready && mem_cs_n && mem_oe_n, "R1 after reset", {req_ready, mem_cs_n, mem_oe_n}, 3'b111);

        for (int i = 0; i < NV; i++) begin
            int p, hold, c0t, bad, tk, tc;
            logic [9:0] base;
            base = 10'h100 + 10'(i * 8);
            p    = int'(VECS[i].div) + 1;
            do_access(VECS[i].div, VECS[i].wm1, VECS[i].dly, int'(VECS[i].rel), base);
            c0t  = int'(VECS[i].cap0) / p;
            hold = c0t - (ACC + 1);
            // R11 one response per word
            chk(ev_cnt == int'(VECS[i].wm1) + 1, $sformatf("R11 vec%0d word count", i),
                ev_cnt, int'(VECS[i].wm1) + 1);
            for (int j = 0; j <= int'(VECS[i].wm1) && j < ev_cnt; j++) begin
                // R3 R4 R5 R6 R7 R8 capture edge
                chk(ev_n[j] == int'(VECS[i].cap0) + j * STEP * p,
                    $sformatf("R4 R5 R8 vec%0d word%0d edge", i, j), ev_n[j],
                    int'(VECS[i].cap0) + j * STEP * p);
                // R5 data from address base+j
                chk(ev_d[j] == mdl(base + 10'(j)), $sformatf("R5 vec%0d word%0d data", i, j),
                    int'(ev_d[j]), int'(mdl(base + 10'(j))));
                chk(!ev_e[j], $sformatf("R11 vec%0d word%0d err", i, j), int'(ev_e[j]), 0);
            end
            // R10 R7 ready return
            chk(rdy_n == int'(VECS[i].rdy), $sformatf("R10 R7 vec%0d ready edge", i),
                rdy_n, int'(VECS[i].rdy));
            // R2 R3 R6 R7 strobe windows, frozen during hold
            bad = 0;
            for (int n = 1; n < int'(VECS[i].rdy) && n < 256; n++) begin
                tk = n / p;
                tc = (tk <= ACC) ? tk : ((tk < c0t) ? ACC : tk - hold);
                if (s_cs[n] != !(tc >= CSON && tc < CSOFF)) bad++;
                if (s_av[n] != !(tc >= AVON && tc < AVOFF)) bad++;
                if (s_oe[n] != !(tc >= OEON && tc < OEOFF)) bad++;
            end
            chk(bad == 0, $sformatf("R2 R6 R7 vec%0d strobe mismatches", i), bad, 0);
            if (rdy_n > 0 && rdy_n < 256)
                chk(s_cs[rdy_n] && s_av[rdy_n] && s_oe[rdy_n], $sformatf("R10 vec%0d idle strobes", i),
                    {s_cs[rdy_n], s_av[rdy_n], s_oe[rdy_n]}, 3'b111);
        end

        // R9 abort after cfg_timeout+1 frozen ticks
        cfg_timeout = 8'd3;
        do_access(2'd0, 2'd0, 2'd0, 255, 10'h040);
        chk(ev_cnt == 1 && ev_n[0] == 9, "R9 abort edge", ev_n[0], 9);
        chk(ev_e[0] == 1'b1, "R9 abort err flag", int'(ev_e[0]), 1);
        chk(rdy_n == 9, "R9 ready after abort", rdy_n, 9);

        // R9 boundary: timeout reached on the last frozen tick
        cfg_timeout = 8'd6;
        do_access(2'd0, 2'd0, 2'd0, 10, 10'h050);
        chk(ev_cnt == 1 && ev_n[0] == 12 && ev_e[0], "R9 boundary abort", ev_n[0], 12);

        // R9 boundary: one more tick allowed, read completes
        cfg_timeout = 8'd7;
        do_access(2'd0, 2'd0, 2'd0, 10, 10'h060);
        chk(ev_cnt == 1 && ev_n[0] == 13 && !ev_e[0], "R9 no abort", ev_n[0], 13);
        chk(ev_d[0] == mdl(10'h060), "R9 no abort data", int'(ev_d[0]), int'(mdl(10'h060)));
        cfg_timeout = 8'd20;

        // R1 reset during an access
        cfg_div = 2'd0; cfg_words = 2'd0; cfg_wait_dly = 2'd0;
        @(negedge clk);
        req_addr = 10'h070; req_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        repeat (4) @(negedge clk);
        chk(!mem_oe_n, "R2 oe active mid access", int'(mem_oe_n), 0);
        rst_n = 1'b0;
        @(negedge clk);
        chk(req_ready && mem_cs_n && mem_adv_n && mem_oe_n && !rsp_valid, "R1 reset mid access",
            {req_ready, mem_cs_n, mem_adv_n, mem_oe_n, rsp_valid}, 5'b11110);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(req_ready && !rsp_valid, "R1 idle after reset", {req_ready, rsp_valid}, 2'b10);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule